// File: doc/BRIEF.md
# Timer Channel with Compare Flag

This block is one timer channel: a 16-bit up-counter, a 16-bit constant register, a control/status byte and a prescale-select byte. All of them sit on a small 8-bit register bus with separate read and write strobes. The counter advances on a prescaled version of a tick input. When an advance lands the counter on the constant value, a sticky compare flag is set. On the next advance the counter returns to zero, so matches repeat with a fixed period.

The flag drives the interrupt output when the interrupt enable is set. Software clears the flag with a two-step read: it reads the status byte while the flag is set, then later reads the counter's low byte. Any other bus accesses may fall between the two reads. The run bit pauses and resumes the count without losing the count value. A system-stop input forces the flag, the run bit and the pending handshake clear.

Top module: `tmr_channel`

## Requirements
- R1: When the counter advances to a value equal to the constant register, the compare flag (status bit 7, address 0) becomes 1 on the next clock and stays 1 until it is cleared.
- R2: A read of the counter low byte (address 2) clears the flag only if a status read made while the flag was 1 came before it. Unrelated accesses in between do not break the sequence, and a counter read with no earlier status read leaves the flag set.
- R3: Reset, or a one-cycle assertion of stopReq, clears the flag, the run bit and the pending handshake. The interrupt enable is left as it was by stopReq, and irq is 0 in the cycle after stopReq.
- R4: irq is 1 exactly while the flag and the interrupt enable (status bit 6, writable) are both 1. Reset clears the interrupt enable.
- R5: The run bit (status bit 4, writable) gates counting. While it is 0 the count holds. Once it is set again, counting resumes from the held value.
- R6: Status bits 5 and 3..0 always read 0. Writes to those bits, and to bit 7, have no effect. The prescale register (address 1) reads its 3-bit field in bits 2..0 and 0 above it.
- R7: A match that occurs in the same cycle as a clearing counter read leaves the flag set, and that read still consumes the handshake.
- R8: With prescale field n, the counter advances once every 2^n tick pulses while running.
- R9: An advance taken while the counter equals the constant loads 0, so matches recur periodically.
- R10: The counter is at addresses 2 (low) and 3 (high), and the constant is at 4 (low) and 5 (high). Reading the counter low byte captures the high byte, and the next high-byte read returns that captured value.
- R11: A bus write to any counter or constant byte takes effect on the next clock and restarts the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stopReq | input | 1 | System stop; clears flag, run bit and handshake |
| tick | input | 1 | Count-rate tick, one pulse per cycle high |
| busAddr | input | 3 | Register address |
| busWrData | input | 8 | Write data |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, one cycle per read; side effects at the clock edge |
| busRdData | output | 8 | Read data, valid while busRd is high |
| irq | output | 1 | Compare interrupt request |

## Verification
The bench drives the clear handshake in several orders. A counter read with no status read before it must leave the flag set; a design that cleared on any counter read would drop irq early. An unrelated read placed between the two steps must not break the sequence. A match placed in the same cycle as the clearing read must keep the flag, and a design with the wrong priority would lose that interrupt. The bench also covers the prescaler phase restart after a counter write, the wrap to zero after a match, and the captured high byte read after the counter has moved on. Each of these gives an off-by-one count or a torn 16-bit value if done wrong.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BUS_W  = 8;
  localparam int CNT_W  = 2 * BUS_W;
  localparam int PS_W   = 3;
  localparam int ADDR_W = 3;
  localparam int DIV_W  = (1 << PS_W) - 1;

  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_PSC  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNTL = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNTH = 3'd3;
  localparam logic [ADDR_W-1:0] A_CONL = 3'd4;
  localparam logic [ADDR_W-1:0] A_CONH = 3'd5;

  localparam int B_FLAG = 7;
  localparam int B_IEN  = 6;
  localparam int B_RUN  = 4;

  typedef struct packed {
    logic             cntWrLo;
    logic             cntWrHi;
    logic             conWrLo;
    logic             conWrHi;
    logic             runEn;
    logic [PS_W-1:0]  psSel;
    logic [BUS_W-1:0] wrData;
  } dpStrobe_t;
endpackage

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  dpStrobe_t        stb,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] constant,
  output logic             advance,
  output logic             matchEvt
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divMask;
  logic [CNT_W-1:0] nextCnt;
  logic             anyWr;
  logic             cntWr;

  always_comb begin
    divMask = '0;
    for (int i = 0; i < DIV_W; i++) divMask[i] = (PS_W'(i) < stb.psSel);
  end

  assign cntWr    = stb.cntWrLo | stb.cntWrHi;
  assign anyWr    = cntWr | stb.conWrLo | stb.conWrHi;
  assign advance  = tick && stb.runEn && (divCnt >= divMask);
  assign nextCnt  = (count == constant) ? '0 : count + CNT_W'(1);
  assign matchEvt = advance && !anyWr && (nextCnt == constant);

  always_ff @(posedge clk) begin
    if (!rstN)                   divCnt <= '0;
    else if (anyWr || advance)   divCnt <= '0;
    else if (tick && stb.runEn)  divCnt <= divCnt + DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else if (cntWr) begin
      if (stb.cntWrLo) count[BUS_W-1:0]     <= stb.wrData;
      if (stb.cntWrHi) count[CNT_W-1:BUS_W] <= stb.wrData;
    end else if (advance) count <= nextCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) constant <= '0;
    else begin
      if (stb.conWrLo) constant[BUS_W-1:0]     <= stb.wrData;
      if (stb.conWrHi) constant[CNT_W-1:BUS_W] <= stb.wrData;
    end
  end
endmodule

// File: rtl/tmr_ctl.sv
module tmr_ctl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopReq,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              matchEvt,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  constant,
  output dpStrobe_t         stb,
  output logic [BUS_W-1:0]  busRdData,
  output logic              irq,
  output logic              flag,
  output logic              armed,
  output logic              runEn
);
  logic            intEn;
  logic [PS_W-1:0] psSel;
  logic [BUS_W-1:0] hiLatch;
  logic statRd, cntLoRd, cntLoRdHiPart, statWr, psWr;

  assign statRd  = busRd && (busAddr == A_STAT);
  assign cntLoRd = busRd && (busAddr == A_CNTL);
  assign cntLoRdHiPart = cntLoRd;
  assign statWr  = busWr && (busAddr == A_STAT);
  assign psWr    = busWr && (busAddr == A_PSC);

  always_ff @(posedge clk) begin
    if (!rstN || stopReq)        flag <= 1'b0;
    else if (matchEvt)           flag <= 1'b1;
    else if (cntLoRd && armed)   flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stopReq)        armed <= 1'b0;
    else if (cntLoRd && armed)   armed <= 1'b0;
    else if (statRd && flag)     armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       intEn <= 1'b0;
    else if (statWr) intEn <= busWrData[B_IEN];
  end

  always_ff @(posedge clk) begin
    if (!rstN || stopReq) runEn <= 1'b0;
    else if (statWr)      runEn <= busWrData[B_RUN];
  end

  always_ff @(posedge clk) begin
    if (!rstN)     psSel <= '0;
    else if (psWr) psSel <= busWrData[PS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)              hiLatch <= '0;
    else if (cntLoRdHiPart) hiLatch <= count[CNT_W-1:BUS_W];
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      A_STAT: begin
        busRdData[B_FLAG] = flag;
        busRdData[B_IEN]  = intEn;
        busRdData[B_RUN]  = runEn;
      end
      A_PSC:  busRdData[PS_W-1:0] = psSel;
      A_CNTL: busRdData = count[BUS_W-1:0];
      A_CNTH: busRdData = hiLatch;
      A_CONL: busRdData = constant[BUS_W-1:0];
      A_CONH: busRdData = constant[CNT_W-1:BUS_W];
      default: busRdData = '0;
    endcase
  end

  assign irq = flag && intEn;

  always_comb begin
    stb         = '0;
    stb.cntWrLo = busWr && (busAddr == A_CNTL);
    stb.cntWrHi = busWr && (busAddr == A_CNTH);
    stb.conWrLo = busWr && (busAddr == A_CONL);
    stb.conWrHi = busWr && (busAddr == A_CONH);
    stb.runEn   = runEn;
    stb.psSel   = psSel;
    stb.wrData  = busWrData;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopReq,
  input  logic              tick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [BUS_W-1:0]  busRdData,
  output logic              irq
);
  dpStrobe_t        stb;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] constant;
  logic             advance;
  logic             matchEvt;
  logic             flag;
  logic             armed;
  logic             runEn;
  logic             cntWrAny;

  assign cntWrAny = stb.cntWrLo | stb.cntWrHi;

  tmr_ctl u_ctl (
    .clk(clk), .rstN(rstN), .stopReq(stopReq),
    .busAddr(busAddr), .busWrData(busWrData), .busWr(busWr), .busRd(busRd),
    .matchEvt(matchEvt), .count(count), .constant(constant),
    .stb(stb), .busRdData(busRdData), .irq(irq),
    .flag(flag), .armed(armed), .runEn(runEn)
  );

  tmr_dp u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .stb(stb),
    .count(count), .constant(constant), .advance(advance), .matchEvt(matchEvt)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              stopReq,
  input logic              irq,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic [BUS_W-1:0]  busRdData,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  constant,
  input logic              advance,
  input logic              matchEvt,
  input logic              flag,
  input logic              armed,
  input logic              runEn,
  input logic              cntWrAny
);
  AST_STOP_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !irq); // R3
  AST_HOLD_CNT: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !cntWrAny) |=> $stable(count)); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (matchEvt && !stopReq) |=> flag); // R7
  AST_KEEP_UNARMED: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !armed && !stopReq) |=> flag); // R2
  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == A_STAT) |-> (busRdData[5] == 1'b0 && busRdData[3:0] == 4'h0)); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !cntWrAny && count == constant) |=> (count == '0)); // R9
endmodule

bind tmr_channel tmr_channel_chk u_chk (
  .clk(clk), .rstN(rstN), .stopReq(stopReq), .irq(irq),
  .busAddr(busAddr), .busRd(busRd), .busRdData(busRdData),
  .count(count), .constant(constant), .advance(advance), .matchEvt(matchEvt),
  .flag(flag), .armed(armed), .runEn(runEn), .cntWrAny(cntWrAny)
);

// File: tb/sim_tmr_channel.sv
module sim_tmr_channel;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stopReq = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busRdData;
  logic       irq;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_channel u0 (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .tick(tick),
    .busAddr(busAddr), .busWrData(busWrData), .busWr(busWr), .busRd(busRd),
    .busRdData(busRdData), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1; #1 d = busRdData;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic pulseTick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic setCnt(input logic [15:0] v);
    wr(3'd2, v[7:0]); wr(3'd3, v[15:8]);
  endtask

  task automatic setCon(input logic [15:0] v);
    wr(3'd4, v[7:0]); wr(3'd5, v[15:8]);
  endtask

  task automatic getCnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd2, lo); rd(3'd3, hi); v = {hi, lo};
  endtask

  task automatic testReset();
    logic [7:0] d; logic [15:0] c;
    rd(3'd0, d); chk("R4 reset status", d, 8'h00);
    rd(3'd1, d); chk("R6 reset prescale", d, 8'h00);
    getCnt(c);   chk("R10 reset count", c, 16'h0000);
    chk("R4 reset irq", irq, 0);
  endtask

  task automatic testReserved();
    logic [7:0] d;
    wr(3'd0, 8'hFF); rd(3'd0, d); chk("R6 status reserved bits", d, 8'h50);
    chk("R4 irq with flag clear", irq, 0);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hFF); rd(3'd1, d); chk("R6 prescale upper bits", d, 8'h07);
    wr(3'd1, 8'h00);
  endtask

  task automatic testHold();
    logic [15:0] c;
    setCon(16'hFFFF); setCnt(16'h0000); wr(3'd0, 8'h10);
    pulseTick(2); getCnt(c); chk("R5 counting", c, 2);
    wr(3'd0, 8'h00); pulseTick(3); getCnt(c); chk("R5 hold while stopped", c, 2);
    wr(3'd0, 8'h10); pulseTick(1); getCnt(c); chk("R5 resume from held", c, 3);
  endtask

  task automatic testPrescale();
    logic [15:0] c;
    wr(3'd1, 8'h02); setCnt(16'h0000);
    pulseTick(3); getCnt(c); chk("R8 no advance before 4 ticks", c, 0);
    pulseTick(1); getCnt(c); chk("R8 advance on 4th tick", c, 1);
    pulseTick(8); getCnt(c); chk("R8 two more periods", c, 3);
  endtask

  task automatic testRestart();
    logic [15:0] c;
    wr(3'd1, 8'h01); setCnt(16'h0005);
    pulseTick(1);
    wr(3'd2, 8'h05);
    pulseTick(1); getCnt(c); chk("R11 phase restarted by write", c, 5);
    pulseTick(1); getCnt(c); chk("R11 advance after full period", c, 6);
    wr(3'd1, 8'h00);
  endtask

  task automatic testMatchWrap();
    logic [15:0] c; logic [7:0] d;
    setCon(16'h0003); setCnt(16'h0000);
    pulseTick(3); getCnt(c); chk("R1 count at match", c, 3);
    pulseTick(1); getCnt(c); chk("R9 wrap to zero", c, 0);
    chk("R4 irq off while disabled", irq, 0);
    wr(3'd0, 8'h50);
    @(negedge clk); chk("R4 irq with flag and enable", irq, 1);
  endtask

  task automatic testHandshake();
    logic [7:0] d;
    rd(3'd0, d); chk("R2 flag kept after unarmed count reads", d, 8'hD0);
    rd(3'd1, d);
    chk("R2 unrelated read keeps flag", irq, 1);
    rd(3'd2, d);
    @(negedge clk); chk("R2 cleared after status then count", irq, 0);
    rd(3'd0, d); chk("R2 status after clear", d, 8'h50);
  endtask

  task automatic testSetWins();
    logic [7:0] d;
    setCnt(16'h0000); pulseTick(3);
    chk("R1 flag raised on match", irq, 1);
    rd(3'd0, d);
    wr(3'd2, 8'h02);
    @(negedge clk); busAddr = 3'd2; busRd = 1'b1; tick = 1'b1;
    @(negedge clk); busRd = 1'b0; tick = 1'b0;
    chk("R7 set wins over clearing read", irq, 1);
    rd(3'd2, d);
    @(negedge clk); chk("R7 handshake consumed", irq, 1);
  endtask

  task automatic testStop();
    logic [7:0] d; logic [15:0] c;
    @(negedge clk); stopReq = 1'b1;
    @(negedge clk); stopReq = 1'b0;
    chk("R3 irq dropped by stop", irq, 0);
    rd(3'd0, d); chk("R3 status after stop", d, 8'h40);
    pulseTick(2); getCnt(c); chk("R3 count frozen after stop", c, 3);
  endtask

  task automatic testLatch();
    logic [7:0] d;
    setCon(16'hFFFF); setCnt(16'h12FF); wr(3'd0, 8'h10);
    rd(3'd2, d); chk("R10 low byte", d, 8'hFF);
    pulseTick(1);
    rd(3'd3, d); chk("R10 latched high byte", d, 8'h12);
    rd(3'd2, d); chk("R10 new low byte", d, 8'h00);
    rd(3'd3, d); chk("R10 new high byte", d, 8'h13);
    rd(3'd4, d); chk("R10 constant low", d, 8'hFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReserved();
    testHold();
    testPrescale();
    testRestart();
    testMatchWrap();
    testHandshake();
    testSetWins();
    testStop();
    testLatch();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule